// File: doc/BRIEF.md
# Pulse Timer Trigger and Interrupt Control

This block holds the 8-bit control/status byte of a 16-bit pulse generator timer and the logic around it. An external trigger pin can start the timer on its rising edge and stop it on its falling edge. Each of the two actions has its own enable bit. The pin is first brought into the clock domain through a synchroniser, and the edges are then detected. The block drives a run level that the timer core follows. The counter and the compare logic sit in the core and are not part of this block.

The block also keeps the timer interrupt flag. A pulse from the core sets the flag. Software clears it by writing 0 to its bit, and writing 1 to that bit changes nothing. A read marked as read-modify-write returns 1 in the flag position. A bit-set or bit-clear sequence aimed at another bit therefore writes 1 back to the flag and cannot clear it by accident. The interrupt request is the flag gated by an enable bit, and it is registered. The remaining bits are plain storage that drives the core: a 2-bit interrupt-source select, an output enable and an output polarity.

Register layout, bit 7 down to bit 0:
- bit 7: stop-on-fall enable
- bit 6: start-on-rise enable
- bit 5: interrupt enable
- bit 4: flag
- bits 3:2: source select
- bit 1: output enable
- bit 0: output polarity

Top module: `ptmr_trig_ctl`

## Requirements
- R1: After reset, every register bit reads 0, and `runOut` and `irqOut` are 0.
- R2: When bit 6 is 1, a rising edge on `trigIn` sets `runOut`. With the default two-stage synchroniser, `runOut` changes 3 clock edges after the pin changes. When bit 6 is 0, rising edges leave `runOut` unchanged.
- R3: When bit 7 is 1, a falling edge on `trigIn` clears `runOut` with the same latency as R2. When bit 7 is 0, falling edges leave `runOut` unchanged.
- R4: A cycle with `timerEvt` high sets the flag (bit 4). The flag reads 1 from the following cycle.
- R5: A write with bit 4 equal to 0 clears the flag. A write with bit 4 equal to 1 leaves the flag unchanged and does not set it.
- R6: While `rmwRead` is 1, `rdData[4]` is 1 and the other bits are true. While `rmwRead` is 0, `rdData[4]` is the true flag value.
- R7: `irqOut` is the flag AND bit 5, registered once. It follows a change of either one cycle later, and it stays 0 while bit 5 is 0.
- R8: If `timerEvt` and a flag-clearing write fall in the same cycle, the flag ends up 1.
- R9: Bits 3:2, 1 and 0 are read/write storage. They drive `srcSel`, `outEn` and `outPol` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data |
| rmwRead | input | 1 | Marks the current read as read-modify-write |
| rdData | output | 8 | Register read data (combinational) |
| trigIn | input | 1 | Asynchronous external trigger |
| timerEvt | input | 1 | Interrupt event pulse from the timer core |
| runOut | output | 1 | Run level to the timer core |
| irqOut | output | 1 | Interrupt request |
| srcSel | output | 2 | Interrupt-source select to the core |
| outEn | output | 1 | Output enable to the core |
| outPol | output | 1 | Output polarity to the core |

## Verification
Each result has its own latency:
- Register writes and the flag update appear one edge after the strobe.
- `irqOut` appears one edge after the flag or enable it depends on.
- `runOut` appears three edges after the trigger pin changes: two synchroniser stages, then the run register.
- `rdData` is combinational.

The bench drives inputs on the falling clock edge and counts whole cycles before it samples on a later falling edge. For the trigger latency it checks that `runOut` has not yet moved one cycle early, and then that it has moved at the expected cycle. When an edge or a write should be ignored, the bench waits past the latency and reads `runOut` or the flag at the ports.

// File: rtl/ptmr_trig_pkg.sv
package ptmr_trig_pkg;
  localparam int REG_W      = 8;
  localparam int SEL_W      = 2;
  localparam int B_STOP_EN  = 7;
  localparam int B_START_EN = 6;
  localparam int B_IRQ_EN   = 5;
  localparam int B_FLAG     = 4;
  localparam int B_SEL_HI   = 3;
  localparam int B_SEL_LO   = 2;
  localparam int B_OUT_EN   = 1;
  localparam int B_OUT_POL  = 0;

  typedef struct packed {
    logic startRun;
    logic stopRun;
    logic flagSet;
    logic flagClr;
    logic cfgWr;
  } strobe_t;
endpackage

// File: rtl/ptmr_trig_ctrl.sv
module ptmr_trig_ctrl
  import ptmr_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    trigIn,
  input  logic    timerEvt,
  input  logic    wrEn,
  input  logic    wrFlagBit,
  input  logic    startEn,
  input  logic    stopEn,
  output strobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          risePulse;
  logic          fallPulse;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= trigIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], trigIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  assign risePulse = syncQ[LAST] & ~prevQ;
  assign fallPulse = ~syncQ[LAST] & prevQ;

  always_comb begin
    strb.startRun = risePulse & startEn;
    strb.stopRun  = fallPulse & stopEn;
    strb.flagSet  = timerEvt;
    strb.flagClr  = wrEn & ~wrFlagBit;
    strb.cfgWr    = wrEn;
  end

  // R2: an edge pulse lasts a single cycle
  p_rise_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    risePulse |=> !risePulse);
  // R3: a falling pulse lasts a single cycle
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |=> !fallPulse);
endmodule

// File: rtl/ptmr_trig_dp.sv
module ptmr_trig_dp
  import ptmr_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [REG_W-2:0] cfgData,
  input  logic             rmwRead,
  output logic [REG_W-1:0] rdData,
  output logic             startEn,
  output logic             stopEn,
  output logic             runOut,
  output logic             irqOut,
  output logic [SEL_W-1:0] srcSel,
  output logic             outEn,
  output logic             outPol
);
  // cfgData is the write byte with the flag bit removed
  localparam int C_STOP_EN  = B_STOP_EN - 1;
  localparam int C_START_EN = B_START_EN - 1;
  localparam int C_IRQ_EN   = B_IRQ_EN - 1;

  logic             stopEnQ, startEnQ, irqEnQ, flagQ, outEnQ, outPolQ;
  logic [SEL_W-1:0] srcSelQ;
  logic             runQ, irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopEnQ  <= 1'b0;
      startEnQ <= 1'b0;
      irqEnQ   <= 1'b0;
      srcSelQ  <= '0;
      outEnQ   <= 1'b0;
      outPolQ  <= 1'b0;
    end else if (strb.cfgWr) begin
      stopEnQ  <= cfgData[C_STOP_EN];
      startEnQ <= cfgData[C_START_EN];
      irqEnQ   <= cfgData[C_IRQ_EN];
      srcSelQ  <= cfgData[B_SEL_HI:B_SEL_LO];
      outEnQ   <= cfgData[B_OUT_EN];
      outPolQ  <= cfgData[B_OUT_POL];
    end
  end

  // the set wins over the clear, so no event is lost
  always_ff @(posedge clk) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (strb.flagSet)  flagQ <= 1'b1;
    else if (strb.flagClr)  flagQ <= 1'b0;
  end

  // the stop wins over the start
  always_ff @(posedge clk) begin
    if (!rstN)              runQ <= 1'b0;
    else if (strb.stopRun)  runQ <= 1'b0;
    else if (strb.startRun) runQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= flagQ & irqEnQ;
  end

  always_comb begin
    rdData                       = '0;
    rdData[B_STOP_EN]            = stopEnQ;
    rdData[B_START_EN]           = startEnQ;
    rdData[B_IRQ_EN]             = irqEnQ;
    rdData[B_FLAG]               = flagQ | rmwRead;
    rdData[B_SEL_HI:B_SEL_LO]    = srcSelQ;
    rdData[B_OUT_EN]             = outEnQ;
    rdData[B_OUT_POL]            = outPolQ;
  end

  assign startEn = startEnQ;
  assign stopEn  = stopEnQ;
  assign runOut  = runQ;
  assign irqOut  = irqQ;
  assign srcSel  = srcSelQ;
  assign outEn   = outEnQ;
  assign outPol  = outPolQ;

  p_start_sets_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startRun && !strb.stopRun) |=> runQ);
  p_stop_clears_run_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopRun |=> !runQ);
  p_event_sets_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.flagSet |=> flagQ);
  p_clear_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagClr && !strb.flagSet) |=> !flagQ);
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.flagSet && !strb.flagClr) |=> $stable(flagQ));
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && irqEnQ) |=> irqQ);
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnQ |=> !irqQ);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagSet && strb.flagClr) |=> flagQ);
endmodule

// File: rtl/ptmr_trig_ctl.sv
module ptmr_trig_ctl
  import ptmr_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        rmwRead,
  output logic [7:0]  rdData,
  input  logic        trigIn,
  input  logic        timerEvt,
  output logic        runOut,
  output logic        irqOut,
  output logic [1:0]  srcSel,
  output logic        outEn,
  output logic        outPol
);
  strobe_t          strb;
  logic             startEn, stopEn;
  logic [REG_W-2:0] cfgData;

  assign cfgData = {wrData[REG_W-1:B_FLAG+1], wrData[B_FLAG-1:0]};

  ptmr_trig_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigIn    (trigIn),
    .timerEvt  (timerEvt),
    .wrEn      (wrEn),
    .wrFlagBit (wrData[B_FLAG]),
    .startEn   (startEn),
    .stopEn    (stopEn),
    .strb      (strb)
  );

  ptmr_trig_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgData (cfgData),
    .rmwRead (rmwRead),
    .rdData  (rdData),
    .startEn (startEn),
    .stopEn  (stopEn),
    .runOut  (runOut),
    .irqOut  (irqOut),
    .srcSel  (srcSel),
    .outEn   (outEn),
    .outPol  (outPol)
  );
endmodule

// File: tb/test_ptmr_trig_ctl.sv
module test_ptmr_trig_ctl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rstN, wrEn, rmwRead, trigIn, timerEvt;
  logic [7:0] wrData, rdData;
  logic       runOut, irqOut, outEn, outPol;
  logic [1:0] srcSel;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptmr_trig_ctl i_ptmr_trig_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rmwRead(rmwRead),
    .rdData(rdData), .trigIn(trigIn), .timerEvt(timerEvt), .runOut(runOut),
    .irqOut(irqOut), .srcSel(srcSel), .outEn(outEn), .outPol(outPol)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; rmwRead = 1'b0;
    trigIn = 1'b0; timerEvt = 1'b0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    chk("R1 register", rdData, 8'h00);
    chk("R1 run", runOut, 0);
    chk("R1 irq", irqOut, 0);
  endtask

  task automatic tTrigger();
    wr(8'h40);
    trigIn = 1'b1;
    cyc(2);
    chk("R2 run not yet", runOut, 0);
    cyc(1);
    chk("R2 start on rise", runOut, 1);
    trigIn = 1'b0;                 // stop disabled
    cyc(4);
    chk("R3 fall ignored", runOut, 1);
    wr(8'hC0);
    trigIn = 1'b1;
    cyc(4);
    chk("R2 run held", runOut, 1);
    trigIn = 1'b0;
    cyc(2);
    chk("R3 run not yet", runOut, 1);
    cyc(1);
    chk("R3 stop on fall", runOut, 0);
    wr(8'h00);
    trigIn = 1'b1;
    cyc(4);
    chk("R2 rise ignored", runOut, 0);
    trigIn = 1'b0;
    cyc(4);
  endtask

  task automatic tFlag();
    timerEvt = 1'b1;
    cyc(1);
    timerEvt = 1'b0;
    chk("R4 flag set", rdData[4], 1);
    cyc(2);
    chk("R7 irq gated off", irqOut, 0);
    wr(8'h30);
    chk("R5 write one keeps flag", rdData[4], 1);
    chk("R7 irq not yet", irqOut, 0);
    cyc(1);
    chk("R7 irq asserted", irqOut, 1);
    wr(8'h20);
    chk("R5 write zero clears", rdData[4], 0);
    chk("R7 irq still high", irqOut, 1);
    cyc(1);
    chk("R7 irq dropped", irqOut, 0);
    wr(8'h30);
    chk("R5 write one does not set", rdData[4], 0);
  endtask

  task automatic tRmw();
    wr(8'h25);
    rmwRead = 1'b1;
    #1;
    chk("R6 rmw read", rdData, 8'h35);
    rmwRead = 1'b0;
    #1;
    chk("R6 normal read", rdData, 8'h25);
    cyc(1);
  endtask

  task automatic tPriority();
    wrEn = 1'b1; wrData = 8'h20; timerEvt = 1'b1;
    cyc(1);
    wrEn = 1'b0; timerEvt = 1'b0;
    chk("R8 set wins", rdData[4], 1);
    wr(8'h00);
  endtask

  task automatic tPlain();
    wr(8'h0D);
    chk("R9 sel", srcSel, 3);
    chk("R9 outEn", outEn, 0);
    chk("R9 outPol", outPol, 1);
    chk("R9 readback", rdData, 8'h0D);
    wr(8'h06);
    chk("R9 sel b", srcSel, 1);
    chk("R9 outEn b", outEn, 1);
    chk("R9 outPol b", outPol, 0);
  endtask

  initial begin
    tReset();
    tTrigger();
    tFlag();
    tRmw();
    tPriority();
    tPlain();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule